// File: doc/BRIEF.md
# Master Clock Source Selector and Prescaler

This block derives a master clock from one of several candidate source clocks. Every source is presented as a one-cycle tick in a single fast reference clock domain. The block picks one source and divides its tick stream by a programmable factor of 1, 2, 3, 4, 8, 16, 32 or 64. Source changes use enable-based sequencing, so no analog clock switch is needed. The block drives three outputs:

- a level `mclk_o`, which shows the phase of the divided clock;
- a one-cycle enable `mclk_ce_o`, which marks the start of each master clock period;
- a ready flag and an interrupt pulse, which tell software when a new setting is in effect.

Software writes one configuration word, which holds a divide code and a source index. The new setting is held until the master clock period in progress ends, so no period is ever cut short. The ready flag drops on the write. It rises again when the first full period of the new setting completes, and the interrupt pulses in that same cycle.

Top module: `mclk_gen`

## Requirements
- R1: The source index sits in write bits [4 +: SEL_W] and picks which tick input drives the prescaler. An index at or above N_SRC falls back to source 0, the main clock.
- R2: The divide code sits in write bits [3:0]. Codes 0 to 7 divide by 1, 2, 3, 4, 8, 16, 32 and 64 in that order. `mclk_ce_o` pulses once for every that many ticks of the selected source.
- R3: Divide codes 8 to 15 behave as divide-by-1.
- R4: `mclk_o` is high for the first max(1, divide/2) source ticks of each period and low for the rest of it.
  - For divide-by-3 this gives one high tick and two low ticks.
  - For divide-by-1 it stays high.
  - `mclk_o` is high whenever `mclk_ce_o` is high.
- R5: After reset the block behaves as follows:
  - It selects source 0 and divides by 1.
  - `rdy_o` is 1 and `irq_o` is 0.
  - The first tick of source 0 after reset produces a `mclk_ce_o` pulse.
- R6: `rdy_o` is low in the cycle after any write.
- R7: A written setting is adopted only at the end of the period in progress, so the period that contains the write keeps its old length.
- R8: `rdy_o` rises together with the `mclk_ce_o` pulse that closes the first full period of the new setting.
- R9: `irq_o` is a one-cycle pulse, asserted exactly in the cycles where `rdy_o` rises.
- R10: A write made while a previous change is still pending restarts the handshake, and the last written setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 4+SEL_W | Divide code [3:0], source index [4 +: SEL_W] |
| src_tick_i | input | N_SRC | One-cycle tick per candidate source clock period |
| mclk_o | output | 1 | Master clock phase level |
| mclk_ce_o | output | 1 | One-cycle pulse at the start of each master period |
| rdy_o | output | 1 | New setting is in effect |
| irq_o | output | 1 | One-cycle pulse when `rdy_o` rises |

## Verification
The bench builds the block with the default N_SRC of 4. It drives the sources with ticks every 1, 2, 3 and 4 reference cycles, so each source has a distinct period of its own. The bench sweeps every source against all sixteen divide codes. Because the source periods differ, a wrong source choice or a wrong divide shows up directly in the measured period and high time. The slow two-cycle source lets a write land strictly inside a period, which brings the deferred-adoption rule and back-to-back writes within reach.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 7;

  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_ADOPT  = 2'd1,
    ST_SETTLE = 2'd2
  } hs_state_t;

  function automatic logic [DIV_W-1:0] div_of(input logic [CODE_W-1:0] code);
    case (code)
      4'd1:    div_of = 7'd2;
      4'd2:    div_of = 7'd3;
      4'd3:    div_of = 7'd4;
      4'd4:    div_of = 7'd8;
      4'd5:    div_of = 7'd16;
      4'd6:    div_of = 7'd32;
      4'd7:    div_of = 7'd64;
      default: div_of = 7'd1;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] high_of(input logic [DIV_W-1:0] div);
    high_of = (div < 7'd2) ? 7'd1 : (div >> 1);
  endfunction
endpackage

// File: rtl/mclk_src_mux.sv
module mclk_src_mux #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;
  logic             in_range;

  for (genvar g = 0; g < N_SRC; g++) begin : g_hit
    assign hit[g] = (32'(sel_i) == g) && src_tick_i[g];
  end

  assign in_range = (32'(sel_i) < N_SRC);
  assign tick_o   = in_range ? (|hit) : src_tick_i[0];
endmodule

// File: rtl/mclk_presc.sv
module mclk_presc
  import mclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             boundary_o,
  output logic             mclk_o,
  output logic             ce_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W-1:0] hi_len;

  assign cnt_nx     = cnt + 1'b1;
  assign hi_len     = high_of(div_i);
  assign boundary_o = tick_i && (cnt == div_i - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt    <= '0;
      mclk_o <= 1'b0;
      ce_o   <= 1'b0;
    end else begin
      ce_o <= 1'b0;
      if (tick_i) begin
        if (boundary_o) begin
          cnt    <= '0;
          ce_o   <= 1'b1;
          mclk_o <= 1'b1;
        end else begin
          cnt    <= cnt_nx;
          mclk_o <= (cnt_nx < hi_len);
        end
      end
    end
  end
endmodule

// File: rtl/mclk_cfg.sv
module mclk_cfg
  import mclk_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CFG_W = CODE_W + SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             boundary_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [DIV_W-1:0] div_o,
  output logic             rdy_o,
  output logic             irq_o
);
  logic [SEL_W-1:0]  pend_sel;
  logic [CODE_W-1:0] pend_code;
  hs_state_t         st;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_sel  <= '0;
      pend_code <= '0;
      sel_o     <= '0;
      div_o     <= 7'd1;
      st        <= ST_READY;
      rdy_o     <= 1'b1;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (boundary_i) begin
        sel_o <= pend_sel;
        div_o <= div_of(pend_code);
      end
      if (wr_en_i) begin
        pend_code <= wr_data_i[CODE_W-1:0];
        pend_sel  <= wr_data_i[CODE_W +: SEL_W];
        st        <= ST_ADOPT;
        rdy_o     <= 1'b0;
      end else if (boundary_i) begin
        case (st)
          ST_ADOPT:  st <= ST_SETTLE;
          ST_SETTLE: begin
            st    <= ST_READY;
            rdy_o <= 1'b1;
            irq_o <= 1'b1;
          end
          default:   st <= ST_READY;
        endcase
      end
    end
  end
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_pkg::*;
#(
  parameter  int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CFG_W = CODE_W + SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [N_SRC-1:0] src_tick_i,
  output logic             mclk_o,
  output logic             mclk_ce_o,
  output logic             rdy_o,
  output logic             irq_o
);
  logic [SEL_W-1:0] act_sel;
  logic [DIV_W-1:0] act_div;
  logic             sel_tick;
  logic             boundary;

  mclk_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .src_tick_i (src_tick_i),
    .sel_i      (act_sel),
    .tick_o     (sel_tick)
  );

  mclk_presc u_presc (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (sel_tick),
    .div_i      (act_div),
    .boundary_o (boundary),
    .mclk_o     (mclk_o),
    .ce_o       (mclk_ce_o)
  );

  mclk_cfg #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .boundary_i (boundary),
    .sel_o      (act_sel),
    .div_o      (act_div),
    .rdy_o      (rdy_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [N_SRC-1:0] src_tick_i,
  input logic             mclk_o,
  input logic             mclk_ce_o,
  input logic             rdy_o,
  input logic             irq_o
);
  p_rdy_drop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> !rdy_o);

  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |=> !irq_o);

  p_irq_on_rise_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rdy_o) |-> irq_o);

  p_irq_only_rise_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $rose(rdy_o));

  p_rdy_with_ce_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rdy_o) |-> mclk_ce_o);

  p_ce_high_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    mclk_ce_o |-> mclk_o);

  p_ce_needs_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    mclk_ce_o |-> $past(|src_tick_i));
endmodule

bind mclk_gen mclk_gen_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .wr_en_i    (wr_en_i),
  .src_tick_i (src_tick_i),
  .mclk_o     (mclk_o),
  .mclk_ce_o  (mclk_ce_o),
  .rdy_o      (rdy_o),
  .irq_o      (irq_o)
);

// File: tb/mclk_gen_tb_top.sv
module mclk_gen_tb_top;
  localparam int N_SRC = 4;
  localparam int CFG_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [N_SRC-1:0] src_tick = '0;
  logic             mclk, ce, rdy, irq;
  int               checks = 0;
  int               errors = 0;
  int               cyc = 0;

  always #5 clk = ~clk;

  mclk_gen #(.N_SRC(N_SRC)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .src_tick_i (src_tick),
    .mclk_o     (mclk),
    .mclk_ce_o  (ce),
    .rdy_o      (rdy),
    .irq_o      (irq)
  );

  // source s ticks every s+1 reference cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int s = 0; s < N_SRC; s++) src_tick[s] <= ((cyc + 1) % (s + 1) == 0);
  end

  function automatic int exp_div(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 8;  5: return 16; 6: return 32; 7: return 64;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic do_write(input int sel, input int code);
    wr_data = CFG_W'((sel << 4) | code);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    chk("R6 rdy low after write", int'(rdy), 0);
  endtask

  task automatic wait_rdy(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (rdy) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_ce();
    for (int i = 0; i < 3000; i++) begin
      if (ce) break;
      @(negedge clk);
    end
  endtask

  // at a ce cycle: returns cycles to next ce and mclk high count in between
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      hi += int'(mclk);
      len++;
      @(negedge clk);
    end while (!ce && len < 3000);
  endtask

  initial begin
    int len, hi, p, d, h;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R5 reset state: source 0 ticks every cycle, divide 1
    chk("R5 rdy after reset", int'(rdy), 1);
    chk("R5 irq after reset", int'(irq), 0);
    chk("R5 ce every tick", int'(ce), 1);
    chk("R5 mclk high div1", int'(mclk), 1);
    @(negedge clk);
    chk("R5 ce next tick", int'(ce), 1);

    // R1 R2 R3 R4 R8 R9 sweep of every source against every code
    for (int s = 0; s < N_SRC; s++) begin
      for (int c = 0; c < 16; c++) begin
        do_write(s, c);
        wait_rdy(ok);
        chk("R8 ready reached", int'(ok), 1);
        chk("R8 ce with rdy rise", int'(ce), 1);
        chk("R9 irq with rdy rise", int'(irq), 1);
        p = s + 1;
        d = exp_div(c);
        h = (d < 2) ? 1 : d / 2;
        measure(len, hi);
        chk(c > 7 ? "R3 unused code period" : "R2 R1 period", len, d * p);
        chk("R4 high time", hi, h * p);
        chk("R9 irq single", int'(irq), 0);
      end
    end

    // R7: write inside a period, the period keeps its old length
    do_write(1, 3);
    wait_rdy(ok);
    @(negedge clk);
    wait_ce();
    do_write(1, 1);
    len = 1;
    while (!ce && len < 3000) begin len++; @(negedge clk); end
    chk("R7 old period kept", len, 8);
    measure(len, hi);
    chk("R7 new period", len, 4);
    chk("R8 rdy at first new ce", int'(rdy), 1);

    // R10: second write while pending wins
    do_write(0, 7);
    do_write(2, 1);
    wait_rdy(ok);
    chk("R10 ready reached", int'(ok), 1);
    measure(len, hi);
    chk("R10 last write wins", len, 6);
    chk("R10 high time", hi, 3);

    finish_run();
  end
endmodule